// File: doc/BRIEF.md
# Single-Wire Half-Duplex Serial Port

This block is a byte-oriented asynchronous serial port that sends and receives on one shared, open-drain line. It sits on the device side of a host-driven link: the host opens every exchange, and the device only answers. Because both directions use the same wire, the port is only ever receiving or transmitting. It enforces turnaround spacing so that its own replies never collide with host traffic.

A free-running divider makes an oversampling tick every `div_i` clocks, and sixteen ticks make one bit time. The receiver finds a falling edge and checks it at the half-bit point. It then samples each later bit at its centre. It hands each byte to the core as a one-cycle strobe with a framing-error flag. The transmitter takes bytes through a valid/ready handshake. It pulls the pin low only for zero bits and never drives a one. Any character that is arriving has priority over a pending transmit.

Top module: `sw_halfduplex_port`

## Requirements
- R1: A received frame is a low start bit, then 8 data bits with the least significant bit first, then a high stop bit. For each frame, `rx_valid_o` pulses high for exactly one clock, with the byte on `rx_data_o` and `rx_ferr_o` low.
- R2: An accepted transmit byte (`tx_valid_i` and `tx_ready_o` both high at a clock edge) appears on the line as a low start bit, 8 data bits with the least significant bit first, and a high stop bit. Each bit lasts 16 ticks, and one tick is `div_i` clocks.
- R3: The pin is driven (`pin_oe_o` = 1) only during transmitted zero bits, and then `pin_do_o` = 0. While idle, and for every one bit, the pin is released.
- R4: The port never receives and transmits at the same time. Line activity caused by the port's own transmission never produces an `rx_valid_o` pulse.
- R5: After its own stop bit ends, the transmitter waits a further half bit (8 ticks) before it starts another character. `tx_ready_o` stays low during the shifting and during this wait.
- R6: The receiver looks for the next start bit straight after it samples a valid stop bit at mid-bit. A start edge that comes before the stop bit would normally have ended is still received.
- R7: While a character is being received, `tx_ready_o` is low. After a received stop bit, a transmission cannot begin until the end of that stop bit plus half a bit time, which is 16 ticks after the mid-stop sample.
- R8: A low pulse shorter than half a bit is rejected as a glitch, because the start bit is no longer low at its midpoint. No byte is reported.
- R9: A stop bit sampled low reports the byte with `rx_ferr_o` = 1. No new start bit is searched for until the line has returned high.
- R10: After reset, `pin_oe_o` = 0 and `rx_valid_o` = 0, and `tx_ready_o` rises within three clocks while the line is high.
- R11: Reception has priority. Whenever the synchronised line is low, `tx_ready_o` is low, even before a reception has formally started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Clocks per oversampling tick (16 ticks per bit) |
| pin_i | input | 1 | Level sensed on the shared line |
| pin_oe_o | output | 1 | Drive enable for the shared line |
| pin_do_o | output | 1 | Value driven when enabled (always 0 while enabled) |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_ferr_o | output | 1 | Framing error that goes with the strobed byte |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Transmit request |
| tx_ready_o | output | 1 | Port can accept a byte this cycle |

## Verification
The assertions assume that `div_i` is at least 2 and does not change while a character is in flight. They also assume a host that only starts a frame when the device is not transmitting, which holds on a link where the device only answers requests. The bench fixes the divisor at 2 for the whole run. It starts host frames only while the port is idle or receiving, and it models the line as a wired-AND of the host and the port, so the line reads high unless one of them pulls it low. Random bytes in both directions are mixed with directed cases for shortened stop bits, held-low stop bits, short glitches and transmit requests made during reception.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int DATA_W      = 8;
    localparam int OVS         = 16;
    localparam int HALF        = OVS / 2;
    localparam int FRAME_BITS  = DATA_W + 2;
    localparam int CNT_W       = $clog2(OVS);
    localparam int BITN_W      = $clog2(FRAME_BITS);
    localparam int GUARD_TX    = HALF;
    localparam int GUARD_RX    = OVS;
    localparam int GUARD_W     = $clog2(GUARD_RX + 1);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLDLOW
    } rx_state_e;

    typedef enum logic [0:0] {
        TX_IDLE,
        TX_SHIFT
    } tx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
    } rx_word_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_W-1:0] d);
        return {1'b1, d, 1'b0};
    endfunction

endpackage

// File: rtl/swp_sync.sv
module swp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swp_tick.sv
module swp_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;
    logic             wrap;

    assign wrap = (div_i <= DIV_W'(1)) || (cnt_q >= div_i - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_q && div_i > DIV_W'(1)) |=> !tick_q);
endmodule

// File: rtl/swp_rx.sv
module swp_rx
    import swp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              block_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_ferr_o,
    output logic              busy_o,
    output logic              end_o
);
    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BITN_W-1:0] bitn_q;
    logic [DATA_W-1:0] sh_q;
    rx_word_t          word_q;
    logic              valid_q;
    logic              end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bitn_q  <= '0;
            sh_q    <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            end_q   <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (tick_i && !block_i && !line_i) state_q <= RX_START;
                end
                RX_START: if (tick_i) begin
                    if (cnt_q == CNT_W'(HALF - 1)) begin
                        cnt_q  <= '0;
                        bitn_q <= '0;
                        state_q <= line_i ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                RX_DATA: if (tick_i) begin
                    if (cnt_q == CNT_W'(OVS - 1)) begin
                        cnt_q <= '0;
                        sh_q  <= {line_i, sh_q[DATA_W-1:1]};
                        if (bitn_q == BITN_W'(DATA_W - 1)) state_q <= RX_STOP;
                        else bitn_q <= bitn_q + BITN_W'(1);
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                RX_STOP: if (tick_i) begin
                    if (cnt_q == CNT_W'(OVS - 1)) begin
                        cnt_q       <= '0;
                        valid_q     <= 1'b1;
                        word_q.data <= sh_q;
                        word_q.ferr <= !line_i;
                        if (line_i) begin
                            state_q <= RX_IDLE;
                            end_q   <= 1'b1;
                        end else begin
                            state_q <= RX_HOLDLOW;
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                RX_HOLDLOW: if (line_i) begin
                    state_q <= RX_IDLE;
                    end_q   <= 1'b1;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign rx_data_o  = word_q.data;
    assign rx_ferr_o  = word_q.ferr;
    assign rx_valid_o = valid_q;
    assign busy_o     = (state_q != RX_IDLE);
    assign end_o      = end_q;

    // R1
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    // R9
    ferr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && rx_ferr_o) |-> (state_q == RX_HOLDLOW));
endmodule

// File: rtl/swp_tx.sv
module swp_tx
    import swp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    input  logic              rx_busy_i,
    input  logic              rx_end_i,
    input  logic              line_i,
    output logic              active_o,
    output logic              bit_o
);
    tx_state_e             state_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [BITN_W-1:0]     bitn_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [GUARD_W-1:0]    guard_q;
    logic                  ready;

    assign ready = (state_q == TX_IDLE) && (guard_q == '0) &&
                   !rx_busy_i && !rx_end_i && line_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            sh_q    <= '1;
            bitn_q  <= '0;
            cnt_q   <= '0;
            guard_q <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (tx_valid_i && ready) begin
                        sh_q    <= build_frame(tx_data_i);
                        bitn_q  <= '0;
                        cnt_q   <= '0;
                        state_q <= TX_SHIFT;
                    end else if (rx_end_i) begin
                        guard_q <= GUARD_W'(GUARD_RX);
                    end else if (tick_i && guard_q != '0) begin
                        guard_q <= guard_q - GUARD_W'(1);
                    end
                end
                TX_SHIFT: if (tick_i) begin
                    if (cnt_q == CNT_W'(OVS - 1)) begin
                        cnt_q <= '0;
                        sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
                        if (bitn_q == BITN_W'(FRAME_BITS - 1)) begin
                            state_q <= TX_IDLE;
                            guard_q <= GUARD_W'(GUARD_TX);
                        end else begin
                            bitn_q <= bitn_q + BITN_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign tx_ready_o = ready;
    assign active_o   = (state_q == TX_SHIFT);
    assign bit_o      = (state_q == TX_SHIFT) ? sh_q[0] : 1'b1;

    // R2
    tx_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_i && tx_ready_o) |=> (state_q == TX_SHIFT));

    // R5
    guard_after_tx_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active_o) |-> !tx_ready_o);
endmodule

// File: rtl/sw_halfduplex_port.sv
module sw_halfduplex_port
    import swp_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              pin_i,
    output logic              pin_oe_o,
    output logic              pin_do_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_ferr_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o
);
    logic line_s;
    logic tick;
    logic rx_busy;
    logic rx_end;
    logic tx_active;
    logic tx_bit;

    swp_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (line_s)
    );

    swp_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_i),
        .tick_o (tick)
    );

    swp_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .line_i     (line_s),
        .block_i    (tx_active),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .rx_ferr_o  (rx_ferr_o),
        .busy_o     (rx_busy),
        .end_o      (rx_end)
    );

    swp_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .tx_ready_o (tx_ready_o),
        .rx_busy_i  (rx_busy),
        .rx_end_i   (rx_end),
        .line_i     (line_s),
        .active_o   (tx_active),
        .bit_o      (tx_bit)
    );

    assign pin_oe_o = tx_active && !tx_bit;
    assign pin_do_o = tx_bit;

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> !rx_busy);

    // R4
    no_echo_chk: assert property (@(posedge clk) disable iff (rst)
        pin_oe_o |-> !rx_valid_o);
endmodule

// File: tb/tb_sw_halfduplex_port.sv
module tb_sw_halfduplex_port;
    localparam int BIT = 32;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic [15:0] div;
    logic        host_low;
    logic        host_active;
    logic        oe, dout;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_ferr;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_ready;
    wire         line = host_low ? 1'b0 : (oe ? dout : 1'b1);

    sw_halfduplex_port #(.DIV_W(16)) dut (
        .clk (clk), .rst (rst), .div_i (div), .pin_i (line),
        .pin_oe_o (oe), .pin_do_o (dout),
        .rx_data_o (rx_data), .rx_valid_o (rx_valid), .rx_ferr_o (rx_ferr),
        .tx_data_i (tx_data), .tx_valid_i (tx_valid), .tx_ready_o (tx_ready)
    );

    int vectors = 0, errors = 0, cyc = 0;
    int rx_cnt = 0, od_bad = 0, overlap_bad = 0, host_end = 0;
    logic [7:0] rx_hist [64];
    logic       ferr_hist [64];

    always @(negedge clk) begin
        cyc++;
        if (rx_valid) begin
            rx_hist[rx_cnt % 64]   = rx_data;
            ferr_hist[rx_cnt % 64] = rx_ferr;
            rx_cnt++;
        end
        if (oe && dout) od_bad++;
        if (oe && host_active) overlap_bad++;
    end

    function automatic bit in_range(int v, int lo, int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic logic frame_bit(logic [7:0] d, int i);
        logic [9:0] f = {1'b1, d, 1'b0};
        return f[i];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_frame(logic [7:0] d, int stop_len, bit stop_high);
        host_active = 1'b1;
        for (int i = 0; i < 9; i++) begin
            host_low = !frame_bit(d, i);
            wclk(BIT);
        end
        host_low = !stop_high;
        wclk(stop_len);
        host_end = cyc;
        if (stop_high) host_active = 1'b0;
    endtask

    task automatic tx_send(logic [7:0] d);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic tx_capture(output logic [7:0] d, output bit ok, output int t0);
        while (!oe) @(negedge clk);
        t0 = cyc;
        wclk(BIT / 2);
        ok = (line == 1'b0);
        for (int i = 0; i < 8; i++) begin
            wclk(BIT);
            d[i] = line;
        end
        wclk(BIT);
        ok = ok && (line == 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=%0d expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0] a, b, g1, g2;
        bit ok1, ok2;
        int t1, t2, n0;
        void'($urandom(32'd20240611));
        rst = 1'b1; div = 16'(DIV); host_low = 1'b0; host_active = 1'b0;
        tx_data = '0; tx_valid = 1'b0;
        wclk(5);
        rst = 1'b0;
        wclk(3);
        // R10 reset state
        chk(oe == 1'b0, "R10 oe", int'(oe), 0);
        chk(rx_valid == 1'b0, "R10 rx_valid", int'(rx_valid), 0);
        chk(tx_ready == 1'b1, "R10 tx_ready", int'(tx_ready), 1);

        // R1 random received bytes
        for (int k = 0; k < 8; k++) begin
            a = 8'($urandom);
            n0 = rx_cnt;
            host_frame(a, BIT, 1'b1);
            wclk(BIT);
            chk(rx_cnt == n0 + 1, "R1 count", rx_cnt, n0 + 1);
            chk(rx_hist[n0 % 64] == a, "R1 data", int'(rx_hist[n0 % 64]), int'(a));
            chk(ferr_hist[n0 % 64] == 1'b0, "R1 ferr", int'(ferr_hist[n0 % 64]), 0);
        end

        // R2 R4 random transmitted bytes, no echo reception
        for (int k = 0; k < 6; k++) begin
            a = 8'($urandom);
            n0 = rx_cnt;
            fork
                tx_send(a);
                tx_capture(g1, ok1, t1);
            join
            wclk(BIT);
            chk(g1 == a, "R2 data", int'(g1), int'(a));
            chk(ok1, "R2 framing", int'(ok1), 1);
            chk(rx_cnt == n0, "R4 echo", rx_cnt, n0);
            chk(oe == 1'b0, "R3 idle release", int'(oe), 0);
        end

        // R5 back-to-back transmit spacing
        a = 8'($urandom); b = 8'($urandom);
        fork
            begin tx_send(a); tx_send(b); end
            begin tx_capture(g1, ok1, t1); tx_capture(g2, ok2, t2); end
        join
        wclk(BIT);
        chk(in_range(t2 - t1, 10 * BIT + 13, 10 * BIT + 20), "R5 gap", t2 - t1, 10 * BIT + 16);
        chk(g1 == a && g2 == b, "R5 data", int'(g2), int'(b));

        // R7 R11 transmit request during reception
        a = 8'($urandom); b = 8'($urandom);
        n0 = rx_cnt;
        fork
            host_frame(a, BIT, 1'b1);
            begin
                wclk(4);
                chk(tx_ready == 1'b0, "R11 ready on low line", int'(tx_ready), 0);
                wclk(96);
                chk(tx_ready == 1'b0, "R7 ready in rx", int'(tx_ready), 0);
                tx_send(b);
            end
            begin wclk(100); tx_capture(g1, ok1, t1); end
        join
        wclk(BIT);
        chk(in_range(t1 - host_end, BIT / 2, BIT / 2 + 12), "R7 turnaround", t1 - host_end, BIT / 2 + 4);
        chk(g1 == b, "R7 tx data", int'(g1), int'(b));
        chk(rx_hist[n0 % 64] == a, "R7 rx data", int'(rx_hist[n0 % 64]), int'(a));

        // R6 shortened stop bit followed at once by a new start
        a = 8'($urandom); b = 8'($urandom);
        n0 = rx_cnt;
        host_frame(a, 22, 1'b1);
        host_frame(b, BIT, 1'b1);
        wclk(BIT);
        chk(rx_cnt == n0 + 2, "R6 count", rx_cnt, n0 + 2);
        chk(rx_hist[n0 % 64] == a, "R6 first", int'(rx_hist[n0 % 64]), int'(a));
        chk(rx_hist[(n0 + 1) % 64] == b, "R6 second", int'(rx_hist[(n0 + 1) % 64]), int'(b));

        // R8 glitches shorter than half a bit
        n0 = rx_cnt;
        host_low = 1'b1; wclk(3); host_low = 1'b0; wclk(400);
        host_low = 1'b1; wclk(10); host_low = 1'b0; wclk(400);
        chk(rx_cnt == n0, "R8 glitch", rx_cnt, n0);
        chk(tx_ready == 1'b1, "R8 ready after glitch", int'(tx_ready), 1);

        // R9 framing error with the line held low
        a = 8'($urandom);
        n0 = rx_cnt;
        host_frame(a, BIT, 1'b0);
        wclk(4);
        chk(rx_cnt == n0 + 1, "R9 count", rx_cnt, n0 + 1);
        chk(ferr_hist[n0 % 64] == 1'b1, "R9 ferr", int'(ferr_hist[n0 % 64]), 1);
        chk(rx_hist[n0 % 64] == a, "R9 data", int'(rx_hist[n0 % 64]), int'(a));
        wclk(3 * BIT);
        chk(rx_cnt == n0 + 1, "R9 no hunt while low", rx_cnt, n0 + 1);
        chk(tx_ready == 1'b0, "R11 held low", int'(tx_ready), 0);
        host_low = 1'b0; host_active = 1'b0;
        wclk(2 * BIT);
        b = 8'($urandom);
        host_frame(b, BIT, 1'b1);
        wclk(BIT);
        chk(rx_hist[(n0 + 1) % 64] == b, "R9 recovery", int'(rx_hist[(n0 + 1) % 64]), int'(b));
        chk(ferr_hist[(n0 + 1) % 64] == 1'b0, "R9 recovery ferr", int'(ferr_hist[(n0 + 1) % 64]), 0);

        // R3 R4 whole-run line monitors
        chk(od_bad == 0, "R3 drove high", od_bad, 0);
        chk(overlap_bad == 0, "R4 drove during host frame", overlap_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule